// File: doc/BRIEF.md
# Prescaled Modulo Timer

This block is a small periodic timer. An up-counter advances on a prescaled tick and returns to zero once it has passed a programmable limit. Each return to zero raises an overflow flag, and that flag can drive an interrupt line. Software controls the timer through four byte-wide registers on a simple synchronous read/write port. These are a control/status register, a clock configuration register, a read-only count register and a limit register.

The tick comes from one of four sources: every bus clock cycle, a single-cycle fixed-rate strobe, or the rising or falling edge of an external pin. The pin passes through a synchroniser before its edges are detected. A power-of-two prescaler divides the chosen tick by 1 to 256 in nine steps. Software can freeze the timer, restart it from zero, and clear the overflow flag with a read-then-write sequence.

Top module: `mt_timer`

## Requirements
- R1: While running, the count rises by exactly one on every prescaled tick. With the bus-clock source and division by 1, it rises once per clock cycle.
- R2: When the count equals a nonzero limit (register address 3), the next prescaled tick returns the count to 0 and sets the overflow flag (control bit 7). The flag is never set in any other way.
- R3: A limit of 0 makes the counter run through the full range. After 255 it wraps to 0 and sets the flag.
- R4: The clock register's bits 3:0 hold a prescale code p, giving division by 2^p. Any code of 8 or more divides by 256.
- R5: Writing 1 to control bit 5 returns the count and the prescaler to 0, and bit 5 always reads 0. Any write to the clock register or the limit register does the same.
- R6: Control bit 4 (stop) freezes both the count and the prescaler. It is 1 after reset.
- R7: The count register (address 2) is read-only. Writing any value to it leaves the count unchanged.
- R8: A write with control bit 7 at 0 clears the flag only if a read of the control register, made while the flag was set, came first. Any write to the control register cancels that pending clear.
- R9: The interrupt output is high exactly when the flag is set and the interrupt enable (control bit 6) is 1.
- R10: The clock register's bits 5:4 select the source: 0 is the bus clock, 1 the fixed strobe, 2 the external pin's falling edge, 3 its rising edge. Each selected pin edge advances the count once.
- R11: With source 1, the count advances only in cycles where the fixed strobe is high.
- R12: After reset the control register reads 0x10, and the clock, count and limit registers read 0. The interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 2 | Register address: 0 control, 1 clock, 2 count, 3 limit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| fixed_tick | input | 1 | Single-cycle fixed-rate strobe, synchronous to clk |
| ext_clk_pin | input | 1 | Asynchronous external clock pin |
| irq | output | 1 | Overflow interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. The count obeys the old stop value at that edge, so a start write leaves the count at 0 and the first increment lands one edge later. From then on, a bus-sourced count at division 2^p gains one every 2^p edges. An external pin change reaches the count on the third rising edge after it, because of two synchroniser stages and one edge-detect register. The bench drives inputs on the falling edge and reads the combinational read port half a cycle later. It waits four falling edges after each pin change, counts falling edges exactly when predicting counts, and observes counts without the read strobe, so that reading cannot arm a flag clear.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [1:0] {
    SRC_BUS      = 2'd0,
    SRC_FIXED    = 2'd1,
    SRC_EXT_FALL = 2'd2,
    SRC_EXT_RISE = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CLK  = 2'd1,
    RA_CNT  = 2'd2,
    RA_LIM  = 2'd3
  } reg_addr_e;

  // Prescale exponent, saturated at the prescaler depth.
  function automatic int unsigned clamp_exp(input int unsigned code, input int unsigned lim);
    return (code > lim) ? lim : code;
  endfunction

endpackage

// File: rtl/mt_src_sel.sv
module mt_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       fixed_tick,
  input  logic       ext_clk_pin,
  output logic       src_tick
);
  import mt_pkg::*;

  localparam int CHAIN_W = SYNC_STAGES + 1;

  // Synchroniser stages plus one history stage for edge detection.
  logic [CHAIN_W-1:0] chain;
  logic pin_now, pin_old, pin_rise, pin_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-2:0], ext_clk_pin};
  end

  assign pin_now  = chain[SYNC_STAGES-1];
  assign pin_old  = chain[SYNC_STAGES];
  assign pin_rise = pin_now & ~pin_old;
  assign pin_fall = ~pin_now & pin_old;

  always_comb begin
    unique case (src_e'(sel))
      SRC_BUS:      src_tick = 1'b1;
      SRC_FIXED:    src_tick = fixed_tick;
      SRC_EXT_FALL: src_tick = pin_fall;
      SRC_EXT_RISE: src_tick = pin_rise;
      default:      src_tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int DIV_W = 8,
  parameter int PS_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clear,
  input  logic            src_tick,
  input  logic [PS_W-1:0] ps_code,
  output logic            pre_tick
);
  import mt_pkg::*;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_mask;
  int unsigned      exp_v;

  assign exp_v = clamp_exp(32'(ps_code), DIV_W);

  // Low exp_v bits set: a tick is due when all of them are one.
  always_comb begin
    for (int i = 0; i < DIV_W; i++) div_mask[i] = (i < int'(exp_v));
  end

  assign pre_tick = run & src_tick & ((div_cnt & div_mask) == div_mask);

  always_ff @(posedge clk) begin
    if (!rst_n)               div_cnt <= '0;
    else if (clear)           div_cnt <= '0;
    else if (run && src_tick) div_cnt <= div_cnt + 1'b1;
  end

endmodule

// File: rtl/mt_core_counter.sv
module mt_core_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit_reg,
  output logic [CNT_W-1:0] cnt_val,
  output logic             wrap_evt
);

  // A zero limit stands for the full counter range.
  function automatic logic [CNT_W-1:0] wrap_point(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? {CNT_W{1'b1}} : lim;
  endfunction

  logic [CNT_W-1:0] top_v;

  assign top_v    = wrap_point(limit_reg);
  assign wrap_evt = tick & (cnt_val == top_v);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_val <= '0;
    else if (clear)    cnt_val <= '0;
    else if (wrap_evt) cnt_val <= '0;
    else if (tick)     cnt_val <= cnt_val + 1'b1;
  end

endmodule

// File: rtl/mt_timer.sv
module mt_timer #(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 4,
  parameter int PS_MAX      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             fixed_tick,
  input  logic             ext_clk_pin,
  output logic             irq
);
  import mt_pkg::*;

  localparam int DATA_W   = CNT_W;
  localparam int FLAG_BIT = DATA_W - 1;
  localparam int IE_BIT   = DATA_W - 2;
  localparam int RST_BIT  = DATA_W - 3;
  localparam int STOP_BIT = DATA_W - 4;
  localparam int SRC_LSB  = PS_W;

  reg_addr_e        addr_q;
  logic             wr_ctrl, wr_clk, wr_lim, rd_ctrl;
  logic             ovf_flag, irq_en, stop_q, clr_arm;
  logic [1:0]       src_sel;
  logic [PS_W-1:0]  ps_code;
  logic [CNT_W-1:0] limit_reg, cnt_val;
  logic             ctr_clear, src_tick, pre_tick, wrap_evt;

  assign addr_q  = reg_addr_e'(bus_addr);
  assign wr_ctrl = bus_wr & (addr_q == RA_CTRL);
  assign wr_clk  = bus_wr & (addr_q == RA_CLK);
  assign wr_lim  = bus_wr & (addr_q == RA_LIM);
  assign rd_ctrl = bus_rd & (addr_q == RA_CTRL);

  assign ctr_clear = (wr_ctrl & bus_wdata[RST_BIT]) | wr_clk | wr_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      stop_q    <= 1'b1;
      src_sel   <= '0;
      ps_code   <= '0;
      limit_reg <= '0;
    end else begin
      if (wr_ctrl) begin
        irq_en <= bus_wdata[IE_BIT];
        stop_q <= bus_wdata[STOP_BIT];
      end
      if (wr_clk) begin
        src_sel <= bus_wdata[SRC_LSB +: 2];
        ps_code <= bus_wdata[PS_W-1:0];
      end
      if (wr_lim) limit_reg <= bus_wdata;
    end
  end

  // Overflow flag: set wins; a clear needs an armed read first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      clr_arm  <= 1'b0;
    end else begin
      if (wrap_evt)
        ovf_flag <= 1'b1;
      else if (wr_ctrl && clr_arm && !bus_wdata[FLAG_BIT])
        ovf_flag <= 1'b0;
      if (wr_ctrl)
        clr_arm <= 1'b0;
      else if (rd_ctrl && ovf_flag)
        clr_arm <= 1'b1;
    end
  end

  assign irq = ovf_flag & irq_en;

  always_comb begin
    bus_rdata = '0;
    unique case (addr_q)
      RA_CTRL: begin
        bus_rdata[FLAG_BIT] = ovf_flag;
        bus_rdata[IE_BIT]   = irq_en;
        bus_rdata[STOP_BIT] = stop_q;
      end
      RA_CLK: begin
        bus_rdata[SRC_LSB +: 2] = src_sel;
        bus_rdata[PS_W-1:0]     = ps_code;
      end
      RA_CNT:  bus_rdata = cnt_val;
      RA_LIM:  bus_rdata = limit_reg;
      default: bus_rdata = '0;
    endcase
  end

  mt_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .sel(src_sel), .fixed_tick(fixed_tick),
    .ext_clk_pin(ext_clk_pin), .src_tick(src_tick)
  );

  mt_prescaler #(.DIV_W(PS_MAX), .PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(~stop_q), .clear(ctr_clear),
    .src_tick(src_tick), .ps_code(ps_code), .pre_tick(pre_tick)
  );

  mt_core_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .tick(pre_tick),
    .limit_reg(limit_reg), .cnt_val(cnt_val), .wrap_evt(wrap_evt)
  );

endmodule

// File: rtl/mt_timer_chk.sv
module mt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_val,
  input logic             ovf_flag,
  input logic             irq_en,
  input logic             stop_q,
  input logic             irq,
  input logic             wrap_evt,
  input logic             pre_tick,
  input logic             ctr_clear
);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick && !wrap_evt && !ctr_clear |=> cnt_val == $past(cnt_val) + 1'b1);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && !ctr_clear |=> cnt_val == '0 && ovf_flag);

  p_no_spurious_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag && !wrap_evt |=> !ovf_flag);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clear |=> cnt_val == '0);

  p_stop_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !pre_tick);

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !ctr_clear |=> $stable(cnt_val));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag && irq_en);

  p_irq_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && irq_en |-> irq);

endmodule

bind mt_timer mt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .ovf_flag(ovf_flag),
  .irq_en(irq_en), .stop_q(stop_q), .irq(irq), .wrap_evt(wrap_evt),
  .pre_tick(pre_tick), .ctr_clear(ctr_clear)
);

// File: tb/test_mt_timer.sv
`timescale 1ns/1ps
module test_mt_timer;

  localparam logic [1:0] A_CTRL = 2'd0, A_CLK = 2'd1, A_CNT = 2'd2, A_LIM = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       fixed_tick = 1'b0, ext_clk_pin = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  mt_timer i_mt_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fixed_tick(fixed_tick), .ext_clk_pin(ext_clk_pin), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    peek(a, v);
    chk(req, v, exp);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; fixed_tick = 1'b0; ext_clk_pin = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic start(input logic [7:0] lim, input logic [7:0] cfg, input logic [7:0] ctrl);
    wr(A_LIM, lim);
    wr(A_CLK, cfg);
    wr(A_CTRL, ctrl);
  endtask

  task automatic t_reset;
    do_reset();
    chk_reg("R12 ctrl", A_CTRL, 8'h10);
    chk_reg("R12 clk", A_CLK, 8'h00);
    chk_reg("R12 cnt", A_CNT, 8'h00);
    chk_reg("R12 lim", A_LIM, 8'h00);
    chk("R12 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_bus_count;
    do_reset(); start(8'h00, 8'h00, 8'h00);
    chk_reg("R1 start", A_CNT, 8'd0);
    cyc(7);  chk_reg("R1 after 7", A_CNT, 8'd7);
    cyc(10); chk_reg("R1 after 17", A_CNT, 8'd17);
  endtask

  task automatic t_modulo;
    do_reset(); start(8'h04, 8'h00, 8'h00);
    cyc(4); chk_reg("R2 at limit", A_CNT, 8'd4); chk_reg("R2 flag low", A_CTRL, 8'h00);
    cyc(1); chk_reg("R2 wrapped", A_CNT, 8'd0); chk_reg("R2 flag set", A_CTRL, 8'h80);
    cyc(3); chk_reg("R2 recount", A_CNT, 8'd3);
  endtask

  task automatic t_free_run;
    do_reset(); start(8'h00, 8'h00, 8'h00);
    cyc(255); chk_reg("R3 at FF", A_CNT, 8'hFF); chk_reg("R3 flag low", A_CTRL, 8'h00);
    cyc(1);   chk_reg("R3 wrapped", A_CNT, 8'h00); chk_reg("R3 flag set", A_CTRL, 8'h80);
  endtask

  task automatic t_prescale;
    do_reset(); start(8'h00, 8'h02, 8'h00);
    cyc(39); chk_reg("R4 div4 39", A_CNT, 8'd9);
    cyc(1);  chk_reg("R4 div4 40", A_CNT, 8'd10);
    wr(A_CLK, 8'h08); chk_reg("R5 clk write clears", A_CNT, 8'd0);
    cyc(256); chk_reg("R4 div256 first", A_CNT, 8'd1);
    cyc(255); chk_reg("R4 div256 hold", A_CNT, 8'd1);
    cyc(1);   chk_reg("R4 div256 second", A_CNT, 8'd2);
    wr(A_CLK, 8'h0F);
    cyc(255); chk_reg("R4 code15 hold", A_CNT, 8'd0);
    cyc(1);   chk_reg("R4 code15 tick", A_CNT, 8'd1);
  endtask

  task automatic t_stop;
    do_reset(); start(8'h00, 8'h00, 8'h00);
    cyc(5); chk_reg("R6 running", A_CNT, 8'd5);
    wr(A_CTRL, 8'h10); chk_reg("R6 last step", A_CNT, 8'd6);
    cyc(10); chk_reg("R6 frozen", A_CNT, 8'd6);
    wr(A_CTRL, 8'h00); chk_reg("R6 resume edge", A_CNT, 8'd6);
    cyc(3); chk_reg("R6 resumed", A_CNT, 8'd9);
  endtask

  task automatic t_ctr_reset;
    do_reset(); start(8'h00, 8'h00, 8'h00);
    cyc(7); chk_reg("R5 before", A_CNT, 8'd7);
    wr(A_CTRL, 8'h20); chk_reg("R5 cleared", A_CNT, 8'd0);
    chk_reg("R5 bit reads 0", A_CTRL, 8'h00);
    cyc(3); chk_reg("R5 counts on", A_CNT, 8'd3);
    wr(A_LIM, 8'h00); chk_reg("R5 limit write clears", A_CNT, 8'd0);
    cyc(2); chk_reg("R5 after limit write", A_CNT, 8'd2);
  endtask

  task automatic t_readonly;
    do_reset(); start(8'h00, 8'h00, 8'h00);
    cyc(5); wr(A_CTRL, 8'h10);
    wr(A_CNT, 8'h00); chk_reg("R7 zero write", A_CNT, 8'd6);
    wr(A_CNT, 8'hAA); chk_reg("R7 AA write", A_CNT, 8'd6);
  endtask

  task automatic t_flag_clear;
    logic [7:0] v;
    do_reset(); start(8'h02, 8'h00, 8'h00);
    cyc(3);
    wr(A_CTRL, 8'h10); chk_reg("R8 unarmed write keeps", A_CTRL, 8'h90);
    rd(A_CTRL, v); chk("R8 read sees flag", v, 8'h90);
    wr(A_CTRL, 8'h90); chk_reg("R8 write 1 keeps", A_CTRL, 8'h90);
    wr(A_CTRL, 8'h10); chk_reg("R8 disarmed keeps", A_CTRL, 8'h90);
    rd(A_CTRL, v);
    wr(A_CTRL, 8'h10); chk_reg("R8 armed clear", A_CTRL, 8'h10);
  endtask

  task automatic t_irq;
    do_reset(); start(8'h02, 8'h00, 8'h40);
    chk("R9 idle", {7'd0, irq}, 8'h00);
    cyc(2); chk("R9 before wrap", {7'd0, irq}, 8'h00);
    cyc(1); chk("R9 after wrap", {7'd0, irq}, 8'h01);
    wr(A_CTRL, 8'h90); chk("R9 disabled", {7'd0, irq}, 8'h00);
    chk_reg("R9 flag kept", A_CTRL, 8'h90);
    wr(A_CTRL, 8'hD0); chk("R9 re-enabled", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_ext(input logic [7:0] cfg, input logic fall);
    do_reset(); start(8'h00, cfg, 8'h00);
    ext_clk_pin = 1'b1; cyc(4);
    chk_reg(fall ? "R10 fall ignores rise" : "R10 rise counted", A_CNT, fall ? 8'd0 : 8'd1);
    ext_clk_pin = 1'b0; cyc(4);
    chk_reg(fall ? "R10 fall counted" : "R10 rise ignores fall", A_CNT, 8'd1);
    for (int i = 0; i < 3; i++) begin
      ext_clk_pin = 1'b1; cyc(4);
      ext_clk_pin = 1'b0; cyc(4);
    end
    chk_reg("R10 four pulses", A_CNT, 8'd4);
  endtask

  task automatic t_fixed;
    do_reset(); start(8'h00, 8'h10, 8'h00);
    cyc(5); chk_reg("R11 idle strobe", A_CNT, 8'd0);
    for (int i = 0; i < 6; i++) begin
      fixed_tick = 1'b1; cyc(1);
      fixed_tick = 1'b0; cyc(3);
    end
    chk_reg("R11 six strobes", A_CNT, 8'd6);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_bus_count();
    t_modulo();
    t_free_run();
    t_prescale();
    t_stop();
    t_ctr_reset();
    t_readonly();
    t_flag_clear();
    t_irq();
    t_ext(8'h30, 1'b0);
    t_ext(8'h20, 1'b1);
    t_fixed();
    finish_run();
  end

endmodule